// File: doc/BRIEF.md
# Mode-Selectable Four-Tap Streaming FIR Filter

This block filters a stream of signed 8-bit samples with a four-tap finite impulse response, y[n] = c0·x[n] + c1·x[n-1] + c2·x[n-2] + c3·x[n-3]. It takes one sample per clock and returns one filtered sample per clock at a fixed latency. All four products are formed in the same cycle and summed by an adder tree. The sum is then rounded back to the sample's scale and clamped to the signed 8-bit range.

A 3-bit mode input picks the coefficient set. Four sets are built in: pass-through, four-point mean, weighted smoothing and a first-difference edge detector. The fifth set is a bank of four coefficients that the surrounding logic loads at run time through a small write port: a write strobe, a tap index and a data byte. The coefficient set is captured together with each sample, so the mode and the writes apply sample by sample with no glitch between them.

The mode has no state machine to step through. Its five codes are held in a named enumeration (PASS, MEAN, SMOOTH, EDGE, USER). The datapath is two register stages: a capture stage, which holds the delay line and the coefficient set, and an output stage, which holds the rounded and clamped result and the valid flag.

Top module: `mode_fir`

## Requirements
- R1: A synchronous reset clears the delay line, the captured coefficient set, the output sample (to 0), the output valid flag, and all four user coefficients (to 0). A user-mode sample that follows reset therefore yields 0.
- R2: Coefficients are signed 8-bit Q1.6 values, so 64 means 1.0. Mode 0 (PASS) uses {64,0,0,0}, so out_sample equals the sample presented two cycles earlier.
- R3: Mode 1 (MEAN) uses the weights {16,16,16,16} on x[n], x[n-1], x[n-2], x[n-3].
- R4: Mode 2 (SMOOTH) uses the weights {8,24,24,8}.
- R5: Mode 3 (EDGE) uses the weights {32,-32,0,0}.
- R6: Mode 4 (USER) uses the four user coefficients. A write with cfg_we high stores cfg_wdata into the tap chosen by cfg_addr (0 = newest sample). A write made in cycle c applies to samples presented in cycle c+1 and later, not to the sample of cycle c.
- R7: Mode codes 5, 6 and 7 behave exactly like mode 0.
- R8: The full-precision sum S gives the result (S + 32) >> 6 with an arithmetic shift, which rounds halves upward. S = 32 gives 1, S = -32 gives 0 and S = -33 gives -1.
- R9: A rounded result above 127 is output as 127, and one below -128 is output as -128.
- R10: out_valid equals in_valid from two cycles earlier. The delay line shifts on every clock whether or not in_valid is high, so every sample presented enters the history.
- R11: Writes to the user coefficients while a preset mode (0 to 3, 5 to 7) is selected leave the output of that preset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_sample; delayed by two cycles to out_valid |
| in_sample | input | 8 | Signed input sample |
| mode | input | 3 | Coefficient set select (0 PASS, 1 MEAN, 2 SMOOTH, 3 EDGE, 4 USER, 5-7 as 0) |
| cfg_we | input | 1 | User coefficient write strobe |
| cfg_addr | input | 2 | User coefficient tap index |
| cfg_wdata | input | 8 | Signed Q1.6 coefficient to write |
| out_valid | output | 1 | Output qualifier |
| out_sample | output | 8 | Signed filtered, rounded, clamped sample |

## Verification
The bench builds the block with its default parameters: 8-bit samples, 8-bit coefficients and 6 fraction bits. At these widths the full sum fits in 19 bits. User coefficients of 127 against full-scale samples push the result past both clamp limits, and single-coefficient sums land on each rounding tie. Random mode codes, including the three aliases, random write traffic and gapped in_valid patterns run against a bench model that keeps its own history and coefficient bank. Directed runs cover the state after reset, the rounding ties, both clamp limits, and write timing in both user and preset modes.

// File: rtl/fir_pkg.sv
package fir_pkg;

    localparam int TAPS   = 4;
    localparam int ADDR_W = $clog2(TAPS);
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_PASS   = 3'd0,
        MODE_MEAN   = 3'd1,
        MODE_SMOOTH = 3'd2,
        MODE_EDGE   = 3'd3,
        MODE_USER   = 3'd4
    } fir_mode_e;

    // Built-in weight of a tap for a preset mode, scaled by 2**frac.
    // Unlisted codes fall back to pass-through.
    function automatic int preset_weight(logic [MODE_W-1:0] m, int tap, int frac);
        int unity;
        unity = 1 << frac;
        unique case (m)
            MODE_MEAN:   return unity / 4;
            MODE_SMOOTH: return (tap == 0 || tap == TAPS - 1) ? unity / 8 : (3 * unity) / 8;
            MODE_EDGE:   return (tap == 0) ? unity / 2 : ((tap == 1) ? -(unity / 2) : 0);
            default:     return (tap == 0) ? unity : 0;
        endcase
    endfunction

endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
    parameter int COEF_W = 8,
    parameter int FRAC_W = 6
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    wr_en,
    input  logic [fir_pkg::ADDR_W-1:0]              wr_addr,
    input  logic [COEF_W-1:0]                       wr_data,
    input  logic [fir_pkg::MODE_W-1:0]              mode,
    output logic [fir_pkg::TAPS*COEF_W-1:0]         sel_coefs
);

    localparam int TAPS = fir_pkg::TAPS;

    logic [COEF_W-1:0] user_q [TAPS];

    // Run-time programmable bank, cleared by reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TAPS; i++) begin
                user_q[i] <= '0;
            end
        end else if (wr_en) begin
            user_q[wr_addr] <= wr_data;
        end
    end

    // Per-tap selection between the preset weight and the user bank.
    for (genvar t = 0; t < TAPS; t++) begin : g_sel
        logic [COEF_W-1:0] preset_c;
        always_comb begin
            preset_c = COEF_W'(fir_pkg::preset_weight(mode, t, FRAC_W));
            if (mode == fir_pkg::MODE_USER) begin
                sel_coefs[t*COEF_W +: COEF_W] = user_q[t];
            end else begin
                sel_coefs[t*COEF_W +: COEF_W] = preset_c;
            end
        end
    end

endmodule

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
    parameter int DATA_W = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [DATA_W-1:0]                 din,
    output logic [fir_pkg::TAPS*DATA_W-1:0]   taps
);

    localparam int TAPS = fir_pkg::TAPS;

    // Slot 0 holds the newest sample; the line advances on every clock.
    for (genvar k = 0; k < TAPS; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                taps[k*DATA_W +: DATA_W] <= '0;
            end else if (k == 0) begin
                taps[k*DATA_W +: DATA_W] <= din;
            end else begin
                taps[k*DATA_W +: DATA_W] <= taps[(k-1)*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int FRAC_W = 6
) (
    input  logic [fir_pkg::TAPS*DATA_W-1:0]  taps,
    input  logic [fir_pkg::TAPS*COEF_W-1:0]  coefs,
    output logic [DATA_W-1:0]                y
);

    localparam int TAPS   = fir_pkg::TAPS;
    localparam int PROD_W = DATA_W + COEF_W;
    localparam int SUM_W  = PROD_W + $clog2(TAPS) + 1;
    localparam int OUT_HI = (1 << (DATA_W - 1)) - 1;
    localparam int OUT_LO = -(1 << (DATA_W - 1));

    logic signed [PROD_W-1:0] prod [TAPS];
    logic signed [SUM_W-1:0]  acc;
    logic signed [SUM_W-1:0]  rounded;
    logic signed [SUM_W-1:0]  scaled;

    // All products in parallel.
    for (genvar i = 0; i < TAPS; i++) begin : g_mul
        assign prod[i] = $signed(taps[i*DATA_W +: DATA_W]) * $signed(coefs[i*COEF_W +: COEF_W]);
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < TAPS; i++) begin
            acc = acc + SUM_W'(prod[i]);
        end
        rounded = acc + SUM_W'(1 << (FRAC_W - 1));
        scaled  = rounded >>> FRAC_W;
        if (scaled > OUT_HI) begin
            y = DATA_W'(OUT_HI);
        end else if (scaled < OUT_LO) begin
            y = DATA_W'(OUT_LO);
        end else begin
            y = DATA_W'(scaled);
        end
    end

endmodule

// File: rtl/mode_fir.sv
module mode_fir #(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int FRAC_W = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [DATA_W-1:0]             in_sample,
    input  logic [fir_pkg::MODE_W-1:0]    mode,
    input  logic                          cfg_we,
    input  logic [fir_pkg::ADDR_W-1:0]    cfg_addr,
    input  logic [COEF_W-1:0]             cfg_wdata,
    output logic                          out_valid,
    output logic [DATA_W-1:0]             out_sample
);

    localparam int TAPS = fir_pkg::TAPS;

    logic [TAPS*COEF_W-1:0] sel_coefs;
    logic [TAPS*COEF_W-1:0] coef_q;
    logic [TAPS*DATA_W-1:0] hist_q;
    logic [DATA_W-1:0]      y_next;
    logic                   cap_valid_q;

    fir_coef_bank #(
        .COEF_W (COEF_W),
        .FRAC_W (FRAC_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .mode      (mode),
        .sel_coefs (sel_coefs)
    );

    // Capture stage: history and the coefficient set travel together.
    fir_delay_line #(
        .DATA_W (DATA_W)
    ) u_line (
        .clk  (clk),
        .rst  (rst),
        .din  (in_sample),
        .taps (hist_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            coef_q      <= '0;
            cap_valid_q <= 1'b0;
        end else begin
            coef_q      <= sel_coefs;
            cap_valid_q <= in_valid;
        end
    end

    fir_mac #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .FRAC_W (FRAC_W)
    ) u_mac (
        .taps  (hist_q),
        .coefs (coef_q),
        .y     (y_next)
    );

    // Output stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_sample <= '0;
            out_valid  <= 1'b0;
        end else begin
            out_sample <= y_next;
            out_valid  <= cap_valid_q;
        end
    end

endmodule

// File: rtl/fir_checker.sv
module fir_checker #(
    parameter int DATA_W = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        in_valid,
    input logic [DATA_W-1:0]           in_sample,
    input logic [fir_pkg::MODE_W-1:0]  mode,
    input logic                        out_valid,
    input logic [DATA_W-1:0]           out_sample
);

    // Clock edges since reset was released, saturating.
    logic [1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (run_cnt != 2'd3) begin
            run_cnt <= run_cnt + 2'd1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_sample == '0 && !out_valid));

    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        (run_cnt >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
        (run_cnt >= 2'd2 && $past(mode, 2) == 3'd0) |-> (out_sample == $past(in_sample, 2)));

    p_alias_r7: assert property (@(posedge clk) disable iff (rst)
        (run_cnt >= 2'd2 && $past(mode, 2) >= 3'd5) |-> (out_sample == $past(in_sample, 2)));

endmodule

bind mode_fir fir_checker #(.DATA_W(DATA_W)) u_fir_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .mode       (mode),
    .out_valid  (out_valid),
    .out_sample (out_sample)
);

// File: tb/test_mode_fir.sv
module test_mode_fir;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_sample;
    logic [2:0] mode;
    logic       cfg_we;
    logic [1:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic       out_valid;
    logic [7:0] out_sample;

    always #10 clk = ~clk;

    mode_fir i_mode_fir (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .mode       (mode),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    int    vectors = 0;
    int    errors  = 0;
    int    hist [4];
    int    bank [4];
    int    p1_y, p2_y;
    bit    p1_v, p2_v;
    string p1_t, p2_t;

    function automatic int weight(int m, int t);
        case (m)
            1:       return 16;
            2:       return (t == 0 || t == 3) ? 8 : 24;
            3:       return (t == 0) ? 32 : ((t == 1) ? -32 : 0);
            4:       return bank[t];
            default: return (t == 0) ? 64 : 0;
        endcase
    endfunction

    function automatic int model_out(int m);
        int s;
        int r;
        s = 0;
        for (int t = 0; t < 4; t++) s += hist[t] * weight(m, t);
        r = (s + 32) >>> 6;
        if (r > 127)  r = 127;
        if (r < -128) r = -128;
        return r;
    endfunction

    function automatic string mode_tag(int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic int sx8(int v);
        return (v & 128) ? (v & 255) - 256 : (v & 255);
    endfunction

    task automatic check(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(bit v, int s, int m, bit we, int a, int d, string tag);
        int y;
        @(negedge clk);
        check(p2_t, int'($signed(out_sample)), p2_y);
        check("R10", int'(out_valid), int'(p2_v));
        for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = sx8(s);
        y = model_out(m);
        p2_y = p1_y; p2_v = p1_v; p2_t = p1_t;
        p1_y = y;    p1_v = v;    p1_t = (tag == "") ? mode_tag(m) : tag;
        if (we) bank[a] = sx8(d);
        in_valid  = v;
        in_sample = 8'(s);
        mode      = 3'(m);
        cfg_we    = we;
        cfg_addr  = 2'(a);
        cfg_wdata = 8'(d);
    endtask

    task automatic write_bank(int c0, int c1, int c2, int c3);
        tick(1'b1, 0, 0, 1'b1, 0, c0, "");
        tick(1'b1, 0, 0, 1'b1, 1, c1, "");
        tick(1'b1, 0, 0, 1'b1, 2, c2, "");
        tick(1'b1, 0, 0, 1'b1, 3, c3, "");
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; in_valid = 1'b0; in_sample = '0; mode = '0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 4; k++) begin hist[k] = 0; bank[k] = 0; end
        p1_y = 0; p2_y = 0; p1_v = 0; p2_v = 0; p1_t = "R1"; p2_t = "R1";
        // R1: outputs cleared while reset is held
        check("R1", int'(out_sample), 0);
        check("R1", int'(out_valid), 0);
        rst = 1'b0;

        // R1: user bank cleared, so user mode yields zero
        for (int i = 0; i < 6; i++) tick(1'b1, 100 - 37 * i, 4, 1'b0, 0, 0, "R1");

        // R2..R5, R7: directed step and impulse through each preset
        for (int m = 0; m < 8; m++) begin
            if (m == 4) continue;
            tick(1'b1, 100, m, 1'b0, 0, 0, "");
            for (int i = 0; i < 4; i++) tick(1'b1, 0, m, 1'b0, 0, 0, "");
            for (int i = 0; i < 4; i++) tick(1'b1, -90, m, 1'b0, 0, 0, "");
        end

        // R6: program the bank; a write applies from the following sample on
        write_bank(10, -20, 30, 5);
        for (int i = 0; i < 6; i++) tick(1'b1, 17 * i - 40, 4, 1'b0, 0, 0, "R6");
        tick(1'b1, 55, 4, 1'b1, 0, 64, "R6");
        tick(1'b1, 55, 4, 1'b0, 0, 0, "R6");
        tick(1'b1, -7, 4, 1'b0, 0, 0, "R6");

        // R8: unit weight on the newest tap only exposes the rounding
        write_bank(1, 0, 0, 0);
        tick(1'b1, 32, 4, 1'b0, 0, 0, "R8");
        tick(1'b1, -32, 4, 1'b0, 0, 0, "R8");
        tick(1'b1, -33, 4, 1'b0, 0, 0, "R8");
        tick(1'b1, 31, 4, 1'b0, 0, 0, "R8");
        tick(1'b1, 96, 4, 1'b0, 0, 0, "R8");
        tick(1'b1, -96, 4, 1'b0, 0, 0, "R8");

        // R9: clamp at both limits
        write_bank(127, 127, 127, 127);
        for (int i = 0; i < 5; i++) tick(1'b1, 127, 4, 1'b0, 0, 0, "R9");
        for (int i = 0; i < 5; i++) tick(1'b1, -128, 4, 1'b0, 0, 0, "R9");

        // R11: bank writes during a preset mode leave its output alone
        for (int i = 0; i < 8; i++)
            tick(1'b1, 60 - 25 * i, 3, 1'b1, i % 4, 200 + i, "R11");
        for (int i = 0; i < 4; i++)
            tick(1'b1, 10 * i, 2, 1'b1, i, 7 * i, "R11");

        // R10: gapped valid, history still advances
        for (int i = 0; i < 12; i++) tick(i[0], 9 * i - 50, 1, 1'b0, 0, 0, "R10");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            tick(1'($urandom_range(0, 1)),
                 int'($urandom_range(0, 255)) - 128,
                 int'($urandom_range(0, 7)),
                 ($urandom_range(0, 3) == 0),
                 int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 255)),
                 "");
        end

        tick(1'b0, 0, 0, 1'b0, 0, 0, "");
        tick(1'b0, 0, 0, 1'b0, 0, 0, "");
        tick(1'b0, 0, 0, 1'b0, 0, 0, "");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule